// File: doc/BRIEF.md
# Register Access Bridge: 4/8-Byte Host Accesses onto a 32-bit AXI4-Lite Master

The block sits between the inbound register-access path of a host link and the register file of an accelerator. The host side issues one request at a time: a read or a write of either 4 or 8 bytes, with an address and a 64-bit data lane. The bridge performs that request as one or two 32-bit AXI4-Lite transactions and then presents one completion carrying the read data and an error flag.

An 8-byte access is carried out as two back-to-back single-word transactions. The lower word goes first at the request address with its two low bits cleared, and the upper word follows at that address plus 4. The two read words are joined into one 64-bit result. A 4-byte access is one transaction, and address bit 2 picks which half of the 64-bit lane carries its data. Any request size other than 4 or 8 bytes is answered straight away with an error completion and never reaches the AXI4-Lite port. The request side is held not-ready from acceptance until the host has taken the completion.

Top module: `mab_top`

## Requirements
- R1: `req_ready` is 1 exactly when no request is in progress. It drops in the cycle after a request is accepted and returns in the cycle after the completion handshake (`cpl_valid` and `cpl_ready` both 1).
- R2: Only one AXI4-Lite transaction is outstanding at any time. The address phase of a word (AW with W, or AR) becomes valid two cycles after the request is accepted, or two cycles after the response of the preceding word. Address and data hold steady while they wait for ready.
- R3: An 8-byte write (`req_size`=8) sends `req_wdata[31:0]` to byte address A&~3 first, then `req_wdata[63:32]` to (A&~3)+4. Every write beat uses `m_wstrb`=4'hF.
- R4: An 8-byte read reads (A&~3) and then (A&~3)+4, and returns `cpl_rdata` = {second word, first word}.
- R5: A 4-byte access (`req_size`=4) is one transaction at A&~3. When A[2]=1 the write data is taken from, and the read data is returned in, `req_wdata`/`cpl_rdata` bits [63:32]. When A[2]=0 bits [31:0] are used. The unused half of a 4-byte read completion is zero.
- R6: `cpl_err` is 1 if any response of the request has a code other than OKAY (2'b00). The second word of an 8-byte access is still performed after an error on the first.
- R7: A request with any `req_size` value other than 4 or 8 starts no AXI4-Lite transaction. It completes in the cycle after acceptance with `cpl_err`=1 and `cpl_rdata`=0.
- R8: `cpl_valid` rises in the cycle after the final response handshake. While `cpl_ready` is 0, `cpl_valid`, `cpl_err` and `cpl_rdata` hold steady.
- R9: `cpl_write` repeats the direction of the request (1 = write). A write completion has `cpl_rdata`=0.
- R10: After reset, `req_ready`=1 and `cpl_valid`, `m_awvalid`, `m_wvalid` and `m_arvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes (4 or 8 legal) |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 64 | Write data lane |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Host takes the completion |
| cpl_write | output | 1 | Direction of the completed request |
| cpl_err | output | 1 | Failure status |
| cpl_rdata | output | 64 | Read data lane |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
Each result has a fixed due time after its trigger. An illegal-size completion is due one cycle after acceptance. Every word's address phase is due two cycles after acceptance or after the previous word's response, with nothing valid in the cycle between. A legal completion is due one cycle after its last response. The bench predicts each handshake from the values it sees at the falling edge, counts cycles down from that edge, and checks `req_ready`, `cpl_valid` and the address-valid outputs on every falling edge against those counters, while a slave with varying ready and response latency logs each transaction so that addresses, data, strobes and merged results can be compared once the completion arrives.

// File: rtl/mab_pkg.sv
package mab_pkg;
  localparam int MAB_AW    = 32;
  localparam int MAB_DW    = 32;
  localparam int MAB_HW    = 2 * MAB_DW;
  localparam int MAB_SW    = 4;
  localparam int MAB_BYTES = MAB_DW / 8;
  localparam int MAB_WSH   = $clog2(MAB_BYTES);
  localparam logic [MAB_SW-1:0] SZ_WORD = MAB_SW'(MAB_BYTES);
  localparam logic [MAB_SW-1:0] SZ_DBL  = MAB_SW'(2 * MAB_BYTES);
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CPL} mab_state_e;

  typedef struct packed {
    logic              legal;
    logic              two;
    logic              lane;
    logic [MAB_AW-1:0] base;
  } mab_dec_t;

  function automatic logic size_legal(input logic [MAB_SW-1:0] sz);
    return (sz == SZ_WORD) || (sz == SZ_DBL);
  endfunction

  function automatic logic [MAB_AW-1:0] word_addr(input logic [MAB_AW-1:0] base,
                                                  input logic hi);
    return base + (MAB_AW'(hi) << MAB_WSH);
  endfunction

  function automatic logic [MAB_DW-1:0] pick_word(input logic [MAB_HW-1:0] lane_data,
                                                  input logic idx);
    return idx ? lane_data[MAB_HW-1:MAB_DW] : lane_data[MAB_DW-1:0];
  endfunction

  function automatic logic [MAB_HW-1:0] place_word(input logic [MAB_HW-1:0] acc,
                                                   input logic [MAB_DW-1:0] w,
                                                   input logic idx);
    logic [MAB_HW-1:0] r;
    r = acc;
    if (idx) r[MAB_HW-1:MAB_DW] = w;
    else     r[MAB_DW-1:0]      = w;
    return r;
  endfunction

  function automatic logic resp_bad(input logic [1:0] code);
    return code != RESP_OKAY;
  endfunction
endpackage

// File: rtl/mab_req_decode.sv
module mab_req_decode
  import mab_pkg::*;
(
  input  logic [MAB_SW-1:0] size,
  input  logic [MAB_AW-1:0] addr,
  output mab_dec_t          dec
);
  localparam logic [MAB_AW-1:0] WORD_MASK = ~(MAB_AW'(MAB_BYTES - 1));

  always_comb begin
    dec.legal = size_legal(size);
    dec.two   = (size == SZ_DBL);
    dec.lane  = addr[MAB_WSH];
    dec.base  = addr & WORD_MASK;
  end
endmodule

// File: rtl/mab_axil_xfer.sv
module mab_axil_xfer
  import mab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic [MAB_AW-1:0] addr,
  input  logic [MAB_DW-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              bad,
  output logic [MAB_DW-1:0] rd_word,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [MAB_AW-1:0] m_awaddr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [MAB_DW-1:0] m_wdata,
  output logic [MAB_BYTES-1:0] m_wstrb,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [MAB_AW-1:0] m_araddr,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [MAB_DW-1:0] m_rdata,
  input  logic [1:0]        m_rresp
);
  logic              busy_q, wr_q, aw_pend, w_pend, ar_pend;
  logic [MAB_AW-1:0] addr_q;
  logic [MAB_DW-1:0] data_q;
  logic              aw_fire, w_fire, ar_fire, b_fire, r_fire;

  assign m_awvalid = aw_pend;
  assign m_wvalid  = w_pend;
  assign m_arvalid = ar_pend;
  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_wdata   = data_q;
  assign m_wstrb   = '1;
  assign m_bready  = busy_q & wr_q & ~aw_pend & ~w_pend;
  assign m_rready  = busy_q & ~wr_q & ~ar_pend;

  assign aw_fire = m_awvalid & m_awready;
  assign w_fire  = m_wvalid & m_wready;
  assign ar_fire = m_arvalid & m_arready;
  assign b_fire  = m_bvalid & m_bready;
  assign r_fire  = m_rvalid & m_rready;

  assign busy    = busy_q;
  assign done    = b_fire | r_fire;
  assign bad     = wr_q ? resp_bad(m_bresp) : resp_bad(m_rresp);
  assign rd_word = m_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      ar_pend <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      wr_q    <= is_wr;
      aw_pend <= is_wr;
      w_pend  <= is_wr;
      ar_pend <= ~is_wr;
      addr_q  <= addr;
      data_q  <= wdata;
    end else begin
      if (aw_fire) aw_pend <= 1'b0;
      if (w_fire)  w_pend  <= 1'b0;
      if (ar_fire) ar_pend <= 1'b0;
      if (done)    busy_q  <= 1'b0;
    end
  end

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_arvalid && (m_awvalid || m_wvalid))); // R2
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R2
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R2
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R2
endmodule

// File: rtl/mab_collect.sv
module mab_collect
  import mab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              clear_bad,
  input  logic              cap,
  input  logic              cap_rd,
  input  logic              idx,
  input  logic [MAB_DW-1:0] word,
  input  logic              bad,
  output logic [MAB_HW-1:0] data,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      err  <= 1'b0;
    end else if (clear) begin
      data <= '0;
      err  <= clear_bad;
    end else if (cap) begin
      err <= err | bad;
      if (cap_rd) data <= place_word(data, word, idx);
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clear |=> err); // R6
endmodule

// File: rtl/mab_top.sv
module mab_top
  import mab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [MAB_SW-1:0] req_size,
  input  logic [MAB_AW-1:0] req_addr,
  input  logic [MAB_HW-1:0] req_wdata,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic              cpl_write,
  output logic              cpl_err,
  output logic [MAB_HW-1:0] cpl_rdata,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [MAB_AW-1:0] m_awaddr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [MAB_DW-1:0] m_wdata,
  output logic [MAB_BYTES-1:0] m_wstrb,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [MAB_AW-1:0] m_araddr,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [MAB_DW-1:0] m_rdata,
  input  logic [1:0]        m_rresp
);
  mab_state_e        state;
  mab_dec_t          dec;
  logic              accept, cpl_fire, kick, last_beat;
  logic              wr_q, two_q, lane_q, beat_q;
  logic [MAB_AW-1:0] base_q;
  logic [MAB_HW-1:0] wdat_q;
  logic              word_idx;
  logic              x_busy, x_done, x_bad;
  logic [MAB_DW-1:0] x_rword;

  mab_req_decode u_dec (.size(req_size), .addr(req_addr), .dec(dec));

  assign req_ready = (state == ST_IDLE);
  assign cpl_valid = (state == ST_CPL);
  assign accept    = req_valid & req_ready;
  assign cpl_fire  = cpl_valid & cpl_ready;
  assign word_idx  = two_q ? beat_q : lane_q;
  assign last_beat = ~two_q | beat_q;
  assign cpl_write = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kick   <= 1'b0;
      wr_q   <= 1'b0;
      two_q  <= 1'b0;
      lane_q <= 1'b0;
      beat_q <= 1'b0;
      base_q <= '0;
      wdat_q <= '0;
    end else begin
      kick <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          wr_q   <= req_write;
          two_q  <= dec.two;
          lane_q <= dec.lane;
          base_q <= dec.base;
          wdat_q <= req_wdata;
          beat_q <= 1'b0;
          kick   <= dec.legal;
          state  <= dec.legal ? ST_RUN : ST_CPL;
        end
        ST_RUN: if (x_done) begin
          if (last_beat) state <= ST_CPL;
          else begin
            beat_q <= 1'b1;
            kick   <= 1'b1;
          end
        end
        ST_CPL: if (cpl_fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  mab_axil_xfer u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start(kick), .is_wr(wr_q),
    .addr(word_addr(base_q, two_q & beat_q)),
    .wdata(pick_word(wdat_q, word_idx)),
    .busy(x_busy), .done(x_done), .bad(x_bad), .rd_word(x_rword),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
  );

  mab_collect u_col (
    .clk(clk), .rst_n(rst_n),
    .clear(accept), .clear_bad(~dec.legal),
    .cap(x_done), .cap_rd(~wr_q), .idx(word_idx),
    .word(x_rword), .bad(x_bad),
    .data(cpl_rdata), .err(cpl_err)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_rdata) && $stable(cpl_err)); // R8
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(m_awvalid || m_wvalid || m_arvalid)); // R7
  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec.legal |=> cpl_valid && cpl_err && (cpl_rdata == '0)); // R7
  AST_NO_XFER_IN_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !x_busy); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> req_ready && !cpl_valid); // R10
endmodule

// File: tb/sim_mab_top.sv
module sim_mab_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [3:0] req_size = 0;
  logic [31:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic cpl_valid, cpl_ready = 0, cpl_write, cpl_err;
  logic [63:0] cpl_rdata;
  logic awvalid, awready = 0, wvalid, wready = 0, bvalid = 0, bready;
  logic [31:0] awaddr, wdata, araddr, rdata = 0;
  logic [3:0] wstrb;
  logic [1:0] bresp = 0, rresp = 0;
  logic arvalid, arready = 0, rvalid = 0, rready;

  mab_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_write(cpl_write), .cpl_err(cpl_err),
    .cpl_rdata(cpl_rdata), .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr),
    .m_wvalid(wvalid), .m_wready(wready), .m_wdata(wdata), .m_wstrb(wstrb),
    .m_bvalid(bvalid), .m_bready(bready), .m_bresp(bresp), .m_arvalid(arvalid),
    .m_arready(arready), .m_araddr(araddr), .m_rvalid(rvalid), .m_rready(rready),
    .m_rdata(rdata), .m_rresp(rresp)
  );

  int nchk = 0, nbad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [1:0] resp_fn(input logic [31:0] a);
    return (a[11:8] == 4'hE) ? 2'b10 : 2'b00;
  endfunction

  // slave and per-cycle reference model
  logic [15:0] lfsr = 16'hACE1;
  bit rand_mode = 0;
  logic [68:0] tlog[$];
  bit aw_got = 0, w_got = 0, b_fired = 0, r_fired = 0;
  logic [31:0] aw_a, w_d; logic [3:0] w_s;
  int b_wait = -1, r_wait = -1, outst = 0;
  logic [31:0] r_a;
  bit busy_m = 0, cpl_ph = 0, cpl_tgt = 0, exp_wr_m = 0;
  int addr_tgt = -1, beats_left = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (addr_tgt > 0) begin
        addr_tgt--;
        if (addr_tgt == 1)
          chk(!(awvalid || wvalid || arvalid), "R2 gap cycle without valid", {61'd0, awvalid, wvalid, arvalid}, 0);
        else if (addr_tgt == 0) begin
          chk(exp_wr_m ? (awvalid && wvalid && !arvalid) : (arvalid && !awvalid),
              "R2 address phase due", {61'd0, awvalid, wvalid, arvalid}, exp_wr_m ? 64'd6 : 64'd1);
          addr_tgt = -1;
        end
      end
      if (cpl_tgt) begin cpl_tgt = 0; cpl_ph = 1; end
      chk(req_ready == !busy_m, "R1 req_ready per cycle", req_ready, !busy_m);
      chk(cpl_valid == cpl_ph, "R8 cpl_valid per cycle", cpl_valid, cpl_ph);
      // slave responses
      if (b_fired) begin bvalid = 0; b_fired = 0; end
      if (r_fired) begin rvalid = 0; r_fired = 0; end
      if (b_wait > 0) b_wait--;
      else if (b_wait == 0 && !bvalid) begin bvalid = 1; bresp = resp_fn(aw_a); b_wait = -1; end
      if (r_wait > 0) r_wait--;
      else if (r_wait == 0 && !rvalid) begin rvalid = 1; rdata = rd_fn(r_a); rresp = resp_fn(r_a); r_wait = -1; end
      awready = rand_mode ? lfsr[0] : 1'b1;
      wready  = rand_mode ? lfsr[3] : 1'b1;
      arready = rand_mode ? lfsr[5] : 1'b1;
      // predict the handshakes of the next rising edge
      if (req_valid && req_ready) begin
        busy_m = 1;
        if (req_size == 4'd4 || req_size == 4'd8) begin
          addr_tgt = 2; exp_wr_m = req_write; beats_left = (req_size == 4'd8) ? 2 : 1;
        end else cpl_tgt = 1;
      end
      if (awvalid && awready) begin
        chk(outst == 0, "R2 single outstanding (aw)", outst, 0);
        outst++; aw_got = 1; aw_a = awaddr;
      end
      if (wvalid && wready) begin w_got = 1; w_d = wdata; w_s = wstrb; end
      if (aw_got && w_got) begin
        tlog.push_back({1'b1, aw_a, w_d, w_s});
        aw_got = 0; w_got = 0; b_wait = rand_mode ? int'(lfsr[2:1]) : 0;
      end
      if (arvalid && arready) begin
        chk(outst == 0, "R2 single outstanding (ar)", outst, 0);
        outst++; r_a = araddr; tlog.push_back({1'b0, araddr, rd_fn(araddr), 4'h0});
        r_wait = rand_mode ? int'(lfsr[7:6]) : 0;
      end
      if ((bvalid && bready) || (rvalid && rready)) begin
        if (bvalid && bready) b_fired = 1; else r_fired = 1;
        outst--; beats_left--;
        if (beats_left == 0) cpl_tgt = 1; else addr_tgt = 2;
      end
      if (cpl_valid && cpl_ready) begin busy_m = 0; cpl_ph = 0; end
    end
  end

  task automatic run(input bit wr, input logic [3:0] sz, input logic [31:0] a,
                     input logic [63:0] wd, input int hold);
    bit legal; int n; logic [31:0] a0, ea[2], ew[2];
    logic [63:0] erd; bit eerr; logic [68:0] e;
    logic [63:0] snap_d; logic snap_e;
    legal = (sz == 4'd4) || (sz == 4'd8);
    n = !legal ? 0 : (sz == 4'd8 ? 2 : 1);
    a0 = a & 32'hFFFF_FFFC;
    ea[0] = a0; ea[1] = a0 + 32'd4;
    erd = 64'd0; eerr = !legal;
    if (n == 2) begin
      ew[0] = wd[31:0]; ew[1] = wd[63:32];
      if (!wr) erd = {rd_fn(ea[1]), rd_fn(ea[0])};
    end else begin
      ew[0] = a[2] ? wd[63:32] : wd[31:0]; ew[1] = 0;
      if (!wr && legal) erd = a[2] ? {rd_fn(a0), 32'd0} : {32'd0, rd_fn(a0)};
    end
    for (int i = 0; i < n; i++) if (resp_fn(ea[i]) != 2'b00) eerr = 1;
    tlog.delete();
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1; req_valid = 0;
    forever begin @(negedge clk); if (cpl_valid) break; end
    chk(cpl_err == eerr, "R6 R7 completion status", cpl_err, eerr);
    chk(cpl_rdata == erd, wr ? "R9 write completion data" : "R4 R5 read completion data", cpl_rdata, erd);
    chk(cpl_write == wr, "R9 direction echo", cpl_write, wr);
    snap_d = cpl_rdata; snap_e = cpl_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(cpl_valid && cpl_rdata == snap_d && cpl_err == snap_e, "R8 completion held", cpl_rdata, snap_d);
    end
    @(posedge clk); #1; cpl_ready = 1;
    @(posedge clk); #1; cpl_ready = 0;
    chk(tlog.size() == n, legal ? "R2 transaction count" : "R7 no transaction", tlog.size(), n);
    for (int i = 0; i < n && i < tlog.size(); i++) begin
      e = wr ? {1'b1, ea[i], ew[i], 4'hF} : {1'b0, ea[i], rd_fn(ea[i]), 4'h0};
      chk(tlog[i] == e, n == 2 ? "R3 R4 word order and content" : "R5 single word content",
          {tlog[i][67:36], tlog[i][35:4]}, {e[67:36], e[35:4]});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1 && !cpl_valid, "R10 reset ready/cpl", {62'd0, req_ready, cpl_valid}, 64'd2);
    chk(!awvalid && !wvalid && !arvalid, "R10 reset valids", {61'd0, awvalid, wvalid, arvalid}, 0);
    rst_n = 1;
    run(1, 4'd4, 32'h0000_0100, 64'h1111_2222_3333_4444, 0);   // R5 low half
    run(1, 4'd4, 32'h0000_0104, 64'h5555_6666_7777_8888, 0);   // R5 high half
    run(0, 4'd4, 32'h0000_0120, 64'd0, 0);                     // R5 read low
    run(0, 4'd4, 32'h0000_0126, 64'd0, 0);                     // R5 read high, low bits dropped
    run(1, 4'd8, 32'h0000_0200, 64'hDEAD_BEEF_CAFE_F00D, 0);   // R3
    run(0, 4'd8, 32'h0000_0308, 64'd0, 2);                     // R4, R8
    run(0, 4'd8, 32'h0000_0DFC, 64'd0, 0);                     // R6 error on second word
    run(1, 4'd8, 32'h0000_0EF8, 64'h0102_0304_0506_0708, 0);   // R6 both words error
    run(1, 4'd4, 32'h0000_0E10, 64'h0, 0);                     // R6 single
    run(0, 4'd1, 32'h0000_0400, 64'd0, 0);                     // R7
    run(1, 4'd2, 32'h0000_0404, 64'hFFFF, 3);                  // R7 and R8
    run(0, 4'd0, 32'h0000_0408, 64'd0, 0);                     // R7
    run(1, 4'd15, 32'h0000_040C, 64'd1, 0);                    // R7
    rand_mode = 1;
    for (int k = 0; k < 40; k++) begin
      logic [3:0] sz;
      sz = (k % 7 == 6) ? 4'd3 : ((k % 2) ? 4'd8 : 4'd4);
      run(lfsr[4], sz, {20'd0, lfsr[11:0]}, {lfsr, ~lfsr, lfsr ^ 16'h3C3C, 16'(k)}, k % 3);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog R1 act=%h exp=%h", 1, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule